// File: doc/BRIEF.md
# Configuration Chain Loader

This block brings an embedded programmable-logic fabric from power-up to a running state. On a start pulse it isolates the fabric's pads and holds the fabric's programming reset for a set number of cycles. It then reads the configuration image one 32-bit word at a time from a memory read port and shifts the image, one bit per pulse of a gated programming clock, into the head of the fabric's serial configuration chain. When the last bit is in, it releases isolation, pulses the operational reset, and lets the operational clock run.

The operational clock comes from the system clock or from an external clock pin, picked by a select input. The chain's tail output can be looped back to the block. The block then compares each bit that leaves the tail with the bit it shifted in a fixed number of pulses earlier, and raises a sticky error flag on any mismatch. Firmware or a small controller supplies the image length and the start pulse, then watches busy and done.

Top module: `cfg_chain_loader`

## Requirements
- R1: After a synchronous reset: fab_isol_n=0 (pads isolated), fab_prog_rst=0, fab_op_rst=0, fab_prog_clk=0, busy=0, done=0 and fab_op_clk held at 0.
- R2: fab_isol_n is 0 whenever fab_prog_rst or fab_prog_clk is 1. fab_prog_rst has returned to 0 before the first rising edge of fab_prog_clk.
- R3: fab_prog_rst stays high for exactly RST_HOLD system clock cycles (16 by default) in each load.
- R4: The number of fab_prog_clk rising edges equals bit_len. Bit k of the image is bit 31-(k mod 32) of the word at address k/32, so each word goes most-significant bit first and a partial last word uses only its top bits. Exactly ceil(bit_len/32) words are read, and read data is taken one cycle after mem_rd_en.
- R5: fab_chain_head holds steady for every cycle in which fab_prog_clk is high.
- R6: fab_isol_n rises only after the last programming clock pulse. fab_op_rst is asserted only while fab_isol_n=1 and lasts exactly RST_HOLD cycles.
- R7: fab_op_clk is 0 until a load completes. After that it follows clk when clk_sel=1 and ext_clk when clk_sel=0.
- R8: A start pulse while busy=1 is ignored: the running load keeps its own length and no second load follows.
- R9: done rises at the end of a load with busy=0 and stays high until the next accepted start, which clears it on the next cycle.
- R10: A synchronous reset in the middle of a load returns the block to idle with the pads isolated and no programming clock.
- R11: With TAP_LEN chain stages looped from head to tail, chain_err stays 0. If the tail disagrees with the bit shifted TAP_LEN pulses earlier, chain_err becomes 1 and holds. Comparisons start only once TAP_LEN pulses have occurred, and the flag clears when the next load starts shifting.
- R12: A bit_len of 0 gives no programming clock pulses and no memory reads, and the full reset and release sequence still completes with done=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load |
| bit_len | input | LEN_W | Number of image bits to shift |
| clk_sel | input | 1 | Operational clock select: 1 = clk, 0 = ext_clk |
| ext_clk | input | 1 | External operational clock pin |
| mem_rd_en | output | 1 | Image word read strobe |
| mem_rd_addr | output | ADDR_W | Image word address |
| mem_rd_data | input | WORD_W | Image word, valid one cycle after the strobe |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | Last load finished; held until next start |
| fab_isol_n | output | 1 | Fabric pad isolation, active low |
| fab_prog_rst | output | 1 | Fabric configuration reset |
| fab_prog_clk | output | 1 | Gated programming clock |
| fab_chain_head | output | 1 | Serial data into the configuration chain |
| fab_chain_tail | input | 1 | Serial data out of the configuration chain |
| fab_op_rst | output | 1 | Fabric user-logic reset |
| fab_op_clk | output | 1 | Fabric operational clock |
| chain_err | output | 1 | Sticky loopback mismatch flag |

## Verification
The bound checker checks the orderings on every cycle. The pads are isolated while programming reset or programming clock is active, chain data is steady across the high phase of the programming clock, and operational reset only appears with the pads released. It also checks the programming reset hold length, the exclusion between done and busy, and the reset state after a mid-run reset. Only the bench scenarios can show the rest: the exact bit order and word count across partial and whole final words, the loopback error flag's dependence on the chain depth, the ignored second start, and the clock multiplexer following either source.

// File: rtl/cfgl_pkg.sv
`timescale 1ns/1ps
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISOL, ST_PRST, ST_SHIFT, ST_DEISO, ST_ORST
  } seq_state_t;

  typedef enum logic [2:0] {
    SR_IDLE, SR_FETCH, SR_LOAD, SR_LOW, SR_HIGH
  } ser_state_t;
endpackage

// File: rtl/cfgl_hold_timer.sv
`timescale 1ns/1ps
module cfgl_hold_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/cfgl_serializer.sv
`timescale 1ns/1ps
module cfgl_serializer
  import cfgl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 11,
  parameter int HALF   = 2,
  parameter int TAP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LEN_W-1:0]  len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              pclk,
  output logic              head,
  input  logic              tail,
  output logic              finished,
  output logic              mismatch
);
  localparam int BW = $clog2(WORD_W);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SW = $clog2(TAP + 1);

  ser_state_t        st;
  logic [WORD_W-1:0] sreg;
  logic [LEN_W-1:0]  left;
  logic [BW-1:0]     bidx;
  logic [PW-1:0]     ph;
  logic [TAP-1:0]    hist;
  logic [SW-1:0]     seen;
  logic [ADDR_W-1:0] addr;
  logic              ph_end;

  assign ph_end  = (ph == PW'(HALF - 1));
  assign rd_en   = (st == SR_FETCH);
  assign rd_addr = addr;
  assign head    = sreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SR_IDLE;
      sreg     <= '0;
      left     <= '0;
      bidx     <= '0;
      ph       <= '0;
      hist     <= '0;
      seen     <= '0;
      addr     <= '0;
      pclk     <= 1'b0;
      finished <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      finished <= 1'b0;
      case (st)
        SR_IDLE: begin
          if (go) begin
            mismatch <= 1'b0;
            seen     <= '0;
            addr     <= '0;
            left     <= len;
            if (len == '0) finished <= 1'b1;
            else           st       <= SR_FETCH;
          end
        end
        SR_FETCH: st <= SR_LOAD;
        SR_LOAD: begin
          sreg <= rd_data;
          addr <= addr + 1'b1;
          bidx <= '0;
          ph   <= '0;
          st   <= SR_LOW;
        end
        SR_LOW: begin
          if (ph_end) begin
            ph   <= '0;
            pclk <= 1'b1;
            hist <= {hist[TAP-2:0], head};
            if (seen != SW'(TAP)) seen <= seen + 1'b1;
            st   <= SR_HIGH;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SR_HIGH: begin
          if (ph_end) begin
            ph   <= '0;
            pclk <= 1'b0;
            if (seen == SW'(TAP) && tail != hist[TAP-1]) mismatch <= 1'b1;
            left <= left - 1'b1;
            if (left == LEN_W'(1)) begin
              finished <= 1'b1;
              st       <= SR_IDLE;
            end else if (bidx == BW'(WORD_W - 1)) begin
              st <= SR_FETCH;
            end else begin
              sreg <= {sreg[WORD_W-2:0], 1'b0};
              bidx <= bidx + 1'b1;
              st   <= SR_LOW;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgl_clk_mux.sv
`timescale 1ns/1ps
module cfgl_clk_mux (
  input  logic sys_clk,
  input  logic ext_clk,
  input  logic sel,
  input  logic run,
  output logic op_clk
);
  assign op_clk = run & (sel ? sys_clk : ext_clk);
endmodule

// File: rtl/cfg_chain_loader.sv
`timescale 1ns/1ps
module cfg_chain_loader
  import cfgl_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 16,
  parameter int RST_HOLD  = 16,
  parameter int PCLK_HALF = 2,
  parameter int TAP_LEN   = 4,
  localparam int ADDR_W   = LEN_W - $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  bit_len,
  input  logic              clk_sel,
  input  logic              ext_clk,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              fab_isol_n,
  output logic              fab_prog_rst,
  output logic              fab_prog_clk,
  output logic              fab_chain_head,
  input  logic              fab_chain_tail,
  output logic              fab_op_rst,
  output logic              fab_op_clk,
  output logic              chain_err
);
  seq_state_t       state, nxt;
  logic [LEN_W-1:0] len_q;
  logic             done_d;
  logic             run_q;
  logic             prst_exp, orst_exp;
  logic             ser_go, ser_fin;

  cfgl_hold_timer #(.LIMIT(RST_HOLD)) prst_tmr_i (
    .clk(clk), .rst(rst), .run(state == ST_PRST), .expire(prst_exp)
  );
  cfgl_hold_timer #(.LIMIT(RST_HOLD)) orst_tmr_i (
    .clk(clk), .rst(rst), .run(state == ST_ORST), .expire(orst_exp)
  );

  assign ser_go = (state == ST_PRST) && prst_exp;

  cfgl_serializer #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
    .HALF(PCLK_HALF), .TAP(TAP_LEN)
  ) ser_i (
    .clk(clk), .rst(rst), .go(ser_go), .len(len_q),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
    .pclk(fab_prog_clk), .head(fab_chain_head), .tail(fab_chain_tail),
    .finished(ser_fin), .mismatch(chain_err)
  );

  cfgl_clk_mux clk_mux_i (
    .sys_clk(clk), .ext_clk(ext_clk), .sel(clk_sel), .run(run_q), .op_clk(fab_op_clk)
  );

  always_comb begin
    nxt    = state;
    done_d = done;
    case (state)
      ST_IDLE:  if (start) begin nxt = ST_ISOL; done_d = 1'b0; end
      ST_ISOL:  nxt = ST_PRST;
      ST_PRST:  if (prst_exp) nxt = ST_SHIFT;
      ST_SHIFT: if (ser_fin) nxt = ST_DEISO;
      ST_DEISO: nxt = ST_ORST;
      ST_ORST:  if (orst_exp) begin nxt = ST_IDLE; done_d = 1'b1; end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      len_q        <= '0;
      done         <= 1'b0;
      busy         <= 1'b0;
      fab_isol_n   <= 1'b0;
      fab_prog_rst <= 1'b0;
      fab_op_rst   <= 1'b0;
      run_q        <= 1'b0;
    end else begin
      state        <= nxt;
      done         <= done_d;
      busy         <= (nxt != ST_IDLE);
      fab_isol_n   <= (nxt == ST_DEISO) || (nxt == ST_ORST) || done_d;
      fab_prog_rst <= (nxt == ST_PRST);
      fab_op_rst   <= (nxt == ST_ORST);
      run_q        <= done_d;
      if (state == ST_IDLE && start) len_q <= bit_len;
    end
  end
endmodule

// File: rtl/cfgl_checker.sv
`timescale 1ns/1ps
module cfgl_checker #(
  parameter int RST_HOLD = 16
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic fab_isol_n,
  input logic fab_prog_rst,
  input logic fab_prog_clk,
  input logic fab_chain_head,
  input logic fab_op_rst
);
  logic [15:0] prst_run;

  always_ff @(posedge clk) begin
    if (rst)               prst_run <= '0;
    else if (fab_prog_rst) prst_run <= prst_run + 1'b1;
    else                   prst_run <= '0;
  end

  a_r2_isolated_during_prog: assert property (@(posedge clk) disable iff (rst)
    (fab_prog_rst || fab_prog_clk) |-> !fab_isol_n);

  a_r2_no_clock_in_reset: assert property (@(posedge clk) disable iff (rst)
    fab_prog_rst |-> !fab_prog_clk);

  a_r3_prog_reset_hold: assert property (@(posedge clk) disable iff (rst)
    ($fell(fab_prog_rst) && !$past(rst)) |-> (prst_run == 16'(RST_HOLD)));

  a_r5_head_stable_high: assert property (@(posedge clk) disable iff (rst)
    fab_prog_clk |-> $stable(fab_chain_head));

  a_r6_op_reset_released: assert property (@(posedge clk) disable iff (rst)
    fab_op_rst |-> fab_isol_n);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && fab_isol_n && !fab_op_rst));

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fab_isol_n && !busy && !done && !fab_prog_clk));
endmodule

bind cfg_chain_loader cfgl_checker #(.RST_HOLD(RST_HOLD)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .fab_isol_n(fab_isol_n),
  .fab_prog_rst(fab_prog_rst), .fab_prog_clk(fab_prog_clk),
  .fab_chain_head(fab_chain_head), .fab_op_rst(fab_op_rst)
);

// File: tb/cfg_chain_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_chain_loader_tb_top;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 11;
  localparam int HOLD   = 16;
  localparam int TAP    = 4;
  localparam int NV     = 7;
  localparam int VLEN  [0:NV-1] = '{37, 32, 1, 70, 64, 3, 0};
  localparam bit VFLIP [0:NV-1] = '{0, 0, 0, 0, 1, 1, 0};
  localparam bit VERR  [0:NV-1] = '{0, 0, 0, 0, 1, 0, 0};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, clk_sel = 1'b0, ext_clk = 1'b0;
  logic [LEN_W-1:0]  bit_len = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [WORD_W-1:0] mem_rd_data = '0;
  logic busy, done, fab_isol_n, fab_prog_rst, fab_prog_clk, fab_chain_head;
  logic fab_chain_tail, fab_op_rst, fab_op_clk, chain_err;

  int checks = 0, errors = 0;
  int rd_cnt = 0, cap_n = 0, prst_cnt = 0, orst_cnt = 0;
  int viol2 = 0, viol6 = 0, deiso_bits = -1;
  logic cap [0:255];
  logic [TAP-1:0] chain = '0;
  logic tail_flip = 1'b0;
  logic isol_prev = 1'b0;

  always #10 clk = ~clk;

  cfg_chain_loader dut_i (
    .clk(clk), .rst(rst), .start(start), .bit_len(bit_len), .clk_sel(clk_sel),
    .ext_clk(ext_clk), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .fab_isol_n(fab_isol_n),
    .fab_prog_rst(fab_prog_rst), .fab_prog_clk(fab_prog_clk),
    .fab_chain_head(fab_chain_head), .fab_chain_tail(fab_chain_tail),
    .fab_op_rst(fab_op_rst), .fab_op_clk(fab_op_clk), .chain_err(chain_err)
  );

  function automatic logic [31:0] pat(int a);
    return 32'hC35A9E17 ^ (32'(a) * 32'h2545F491);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= pat(int'(mem_rd_addr));
      rd_cnt      <= rd_cnt + 1;
    end
  end

  assign fab_chain_tail = chain[TAP-1] ^ tail_flip;

  always @(posedge fab_prog_clk) begin
    chain <= {chain[TAP-2:0], fab_chain_head};
    if (cap_n < 256) cap[cap_n] = fab_chain_head;
    cap_n = cap_n + 1;
    if (fab_isol_n || fab_prog_rst) viol2 = viol2 + 1;
  end

  always @(negedge clk) begin
    if (fab_prog_rst) prst_cnt = prst_cnt + 1;
    if (fab_op_rst) orst_cnt = orst_cnt + 1;
    if (fab_op_rst && !fab_isol_n) viol6 = viol6 + 1;
    if (fab_isol_n && !isol_prev && busy) deiso_bits = cap_n;
    isol_prev = fab_isol_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; prst_cnt = 0; orst_cnt = 0; viol2 = 0; viol6 = 0; deiso_bits = -1;
    rd_cnt = 0;
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    bit_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic run_load(input int len, input bit flip, input bit exp_err);
    int bad;
    @(negedge clk);
    tail_flip = flip;
    clear_mon();
    pulse_start(len);
    wait_done();
    bad = 0;
    for (int k = 0; k < len && k < 256; k++) begin
      if (cap[k] !== pat(k / 32)[31 - (k % 32)]) bad++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9", "done set, busy clear", int'(done), 1);
    chk(cap_n == len, "R4", "pulse count", cap_n, len);
    chk(bad == 0, "R4", "bit order mismatches", bad, 0);
    chk(rd_cnt == (len + 31) / 32, "R4", "word reads", rd_cnt, (len + 31) / 32);
    chk(prst_cnt == HOLD, "R3", "prog reset cycles", prst_cnt, HOLD);
    chk(viol2 == 0, "R2", "pulses while released or in reset", viol2, 0);
    chk(deiso_bits == len, "R6", "bits shifted when isolation released", deiso_bits, len);
    chk(orst_cnt == HOLD && viol6 == 0, "R6", "op reset cycles", orst_cnt, HOLD);
    chk(chain_err == exp_err, "R11", "loopback error flag", int'(chain_err), int'(exp_err));
    if (len == 0) chk(rd_cnt == 0 && cap_n == 0, "R12", "zero length activity", rd_cnt + cap_n, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clk_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fab_isol_n == 0 && fab_prog_rst == 0 && fab_op_rst == 0, "R1", "control pins", int'(fab_isol_n), 0);
    chk(busy == 0 && done == 0 && fab_prog_clk == 0, "R1", "busy/done/pclk", int'(busy) + int'(done), 0);
    @(posedge clk); #5;
    chk(fab_op_clk == 0, "R1", "op clock gated before load", int'(fab_op_clk), 0);

    // vector table walk: R2 R3 R4 R6 R11 R12
    for (int v = 0; v < NV; v++) begin
      bit e;
      e = VFLIP[v] && (VLEN[v] >= TAP);
      chk(e == VERR[v], "R11", "table expectation", int'(VERR[v]), int'(e));
      run_load(VLEN[v], VFLIP[v], VERR[v]);
    end
    tail_flip = 1'b0;

    // R7: operational clock multiplexer
    clk_sel = 1'b1;
    @(posedge clk); #5;
    chk(fab_op_clk == 1, "R7", "op clk follows clk high", int'(fab_op_clk), 1);
    @(negedge clk); #5;
    chk(fab_op_clk == 0, "R7", "op clk follows clk low", int'(fab_op_clk), 0);
    clk_sel = 1'b0; ext_clk = 1'b1; #1;
    chk(fab_op_clk == 1, "R7", "op clk follows ext high", int'(fab_op_clk), 1);
    ext_clk = 1'b0; #1;
    chk(fab_op_clk == 0, "R7", "op clk follows ext low", int'(fab_op_clk), 0);

    // R8: start while busy ignored
    clear_mon();
    pulse_start(40);
    repeat (30) @(negedge clk);
    chk(busy == 1, "R8", "busy mid load", int'(busy), 1);
    pulse_start(5);
    wait_done();
    chk(cap_n == 40, "R8", "length kept", cap_n, 40);
    repeat (10) @(negedge clk);
    chk(busy == 0, "R8", "no second load", int'(busy), 0);

    // R9: done persists until next start
    chk(done == 1, "R9", "done held", int'(done), 1);
    @(negedge clk);
    bit_len = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 0 && busy == 1, "R9", "start clears done", int'(done), 0);
    wait_done();

    // R10: reset mid-run
    clear_mon();
    pulse_start(70);
    for (int i = 0; i < 5000 && cap_n < 5; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(fab_isol_n == 0 && busy == 0 && done == 0, "R10", "idle isolated", int'(fab_isol_n) + int'(busy), 0);
    chk(fab_prog_clk == 0 && fab_prog_rst == 0 && fab_op_rst == 0, "R10", "no programming", int'(fab_prog_clk), 0);
    repeat (4) @(negedge clk);
    chk(fab_prog_clk == 0 && busy == 0, "R10", "stays idle", int'(busy), 0);
    run_load(33, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule